// File: doc/BRIEF.md
# Bit-Manipulation Prefix Execution Unit

This block carries out the second byte of an 8-bit processor's bit-manipulation prefix group. The surrounding core has already fetched the prefix and the opcode byte. It then pulses `start` with the opcode, a flattened copy of the register bank, the current flag byte and the 16-bit HL pointer. The unit picks the operand from a register or from memory at HL. It then applies one of four kinds of operation: a rotate or shift, a single-bit test, a single-bit clear or a single-bit set. It returns the result for write-back to the same place and returns a new flag byte.

Register operands finish in one internal step. Memory operands use a strobe-and-ready handshake. A memory operand is read at HL and followed by one internal cycle, and for every kind except the bit test it is written back to HL. When `done` pulses, the unit also reports the total T-state count of the instruction, including the two fetches done by the core and any wait cycles. One shift variant is not in the documented instruction set. It still executes normally, and `undoc` pulses on the cycle it completes.

The controller has five states:
- `ST_IDLE`: waits for `start`.
- `ST_EXEC`: finishes a register operand.
- `ST_MRD`: holds the read strobe at HL until ready.
- `ST_MINT`: the internal cycle after the read.
- `ST_MWR`: holds the write strobe at HL until ready.

Its transitions:
- `ST_IDLE` goes to `ST_EXEC` on start with a register operand, or to `ST_MRD` on start with the memory operand.
- `ST_EXEC` goes to `ST_IDLE` after one cycle.
- `ST_MRD` goes to `ST_MINT` when ready is seen.
- `ST_MINT` goes to `ST_IDLE` for a bit test, or to `ST_MWR` for any other operation.
- `ST_MWR` goes to `ST_IDLE` when ready is seen.

Top module: `cbx_unit`

## Requirements
- R1: Opcode bits [2:0] choose the operand: codes 0,1,2,3,4,5,7 are registers B,C,D,E,H,L,A, taken from byte k of `reg_bank` (bits 8k+7..8k) for code k. Code 6 is the byte in memory at HL, and byte 6 of `reg_bank` is ignored. A register result is returned on `wb_data` with `wb_sel` equal to the code.
- R2: Opcode bits [7:6] choose the kind: 0 for rotate/shift, 1 for bit test, 2 for bit clear, 3 for bit set. Bits [5:3] give the shift variant or the bit number.
- R3: The shift variants, by bits [5:3], are:
  - 0: rotate left with bit 7 to carry and to bit 0.
  - 1: rotate right with bit 0 to carry and to bit 7.
  - 2: rotate left through carry.
  - 3: rotate right through carry.
  - 4: shift left with a zero fill.
  - 5: shift right keeping bit 7.
  - 6: shift left with a one fill.
  - 7: shift right with a zero fill.

  Each left shift puts the old bit 7 in carry, and each right shift puts the old bit 0 in carry.
- R4: The flag byte has sign in bit 7, zero in bit 6, half-carry in bit 4, parity in bit 2, subtract in bit 1 and carry in bit 0. Bits 5 and 3 always pass through from `flags_in`. A shift sets sign, zero and parity (1 for an even count of ones) from the result, clears half-carry and subtract, loads carry, and raises `flags_we`.
- R5: A bit test sets zero to the inverse of the tested bit, sets half-carry, clears subtract and keeps the other flag bits. It raises `flags_we` but performs no register or memory write.
- R6: Bit clear and bit set change only the selected bit. `flags_out` equals `flags_in`, and `flags_we` stays low.
- R7: A register operand gives `done`, `wb_en` (except for a bit test) and `tstates` = 8 in the cycle after the `start` edge.
- R8: A memory operand drives `mem_addr` = HL with `mem_rd` held until a cycle with `mem_ready`, which captures `mem_rdata`. One internal cycle follows. A bit test then completes with `tstates` = 12 plus the read wait cycles.
- R9: Every other memory operation then holds `mem_wr` with `mem_wdata` = result until `mem_ready`, and `done` comes in that cycle. `tstates` = 15 plus all read and write wait cycles.
- R10: `undoc` pulses together with `done` exactly when bits [7:3] are 6 (the shift with a one fill).
- R11: `start` is ignored while `busy` is high.
- R12: After reset and whenever idle, no strobe, `done`, `wb_en`, `flags_we` or `undoc` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin an instruction (taken only while idle) |
| opcode | input | 8 | second opcode byte |
| reg_bank | input | 64 | register bytes, byte k for operand code k |
| flags_in | input | 8 | current flag byte |
| hl_ptr | input | 16 | HL pointer for the memory operand |
| busy | output | 1 | an instruction is in progress |
| done | output | 1 | completion pulse |
| tstates | output | 8 | total T-state count, valid with done |
| wb_en | output | 1 | register write-back enable |
| wb_sel | output | 3 | register code to write |
| wb_data | output | 8 | register write data |
| flags_we | output | 1 | flag write enable |
| flags_out | output | 8 | new flag byte |
| undoc | output | 1 | undocumented-shift pulse |
| mem_addr | output | 16 | memory address |
| mem_rd | output | 1 | read strobe |
| mem_wr | output | 1 | write strobe |
| mem_wdata | output | 8 | memory write data |
| mem_rdata | input | 8 | memory read data |
| mem_ready | input | 1 | memory cycle completes this clock |

## Verification
The assertions assume that `mem_ready` acts as a completion signal for the active strobe and that the core does not change the meaning of a cycle in mid-transfer. The bench raises `mem_ready` only while `mem_rd` or `mem_wr` is showing, after a chosen number of wait cycles, and otherwise drives it low. Every opcode is run with seven operand values and both carry inputs. The read and write waits vary from zero to two, and a few runs pulse `start` during a busy memory instruction.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

    localparam int BYTE_W  = 8;
    localparam int NREG    = 8;

    localparam logic [2:0] MEM_CODE   = 3'd6;
    localparam logic [2:0] SHIFT_ONES = 3'd6;

    localparam int T_FETCH = 8;
    localparam int T_READ  = 3;
    localparam int T_INT   = 1;
    localparam int T_WRITE = 3;

    localparam int F_S  = 7;
    localparam int F_Z  = 6;
    localparam int F_H  = 4;
    localparam int F_PV = 2;
    localparam int F_N  = 1;
    localparam int F_C  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_MRD,
        ST_MINT,
        ST_MWR
    } cbx_state_e;

    typedef enum logic [1:0] {
        GRP_SHIFT,
        GRP_TEST,
        GRP_CLR,
        GRP_SET
    } cbx_grp_e;

    typedef enum logic [2:0] {
        SH_ROL,
        SH_ROR,
        SH_ROLC,
        SH_RORC,
        SH_SHL0,
        SH_SHRA,
        SH_SHL1,
        SH_SHR0
    } cbx_shift_e;

endpackage

// File: rtl/cbx_operand_sel.sv
module cbx_operand_sel
    import cbx_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NR = NREG,
    localparam int SW = $clog2(NR)
) (
    input  logic [DW*NR-1:0] bank,
    input  logic [SW-1:0]    sel,
    output logic [DW-1:0]    val
);

    logic [DW-1:0] slot [NR];

    for (genvar k = 0; k < NR; k++) begin : g_slot
        assign slot[k] = bank[k*DW +: DW];
    end

    assign val = slot[sel];

endmodule

// File: rtl/cbx_operate.sv
module cbx_operate
    import cbx_pkg::*;
(
    input  logic [7:0] opc,
    input  logic [7:0] val,
    input  logic [7:0] fin,
    output logic [7:0] res,
    output logic [7:0] fout,
    output logic       is_test,
    output logic       flag_upd,
    output logic       is_undoc
);

    cbx_grp_e   grp;
    cbx_shift_e shv;
    logic [2:0] bitn;
    logic       cy;

    assign grp  = cbx_grp_e'(opc[7:6]);
    assign shv  = cbx_shift_e'(opc[5:3]);
    assign bitn = opc[5:3];

    assign is_test  = (grp == GRP_TEST);
    assign flag_upd = (grp == GRP_SHIFT) || (grp == GRP_TEST);
    assign is_undoc = (grp == GRP_SHIFT) && (opc[5:3] == SHIFT_ONES);

    always_comb begin
        res  = val;
        fout = fin;
        cy   = fin[F_C];
        unique case (grp)
            GRP_SHIFT: begin
                unique case (shv)
                    SH_ROL:  begin res = {val[6:0], val[7]};     cy = val[7]; end
                    SH_ROR:  begin res = {val[0], val[7:1]};     cy = val[0]; end
                    SH_ROLC: begin res = {val[6:0], fin[F_C]};   cy = val[7]; end
                    SH_RORC: begin res = {fin[F_C], val[7:1]};   cy = val[0]; end
                    SH_SHL0: begin res = {val[6:0], 1'b0};       cy = val[7]; end
                    SH_SHRA: begin res = {val[7], val[7:1]};     cy = val[0]; end
                    SH_SHL1: begin res = {val[6:0], 1'b1};       cy = val[7]; end
                    SH_SHR0: begin res = {1'b0, val[7:1]};       cy = val[0]; end
                endcase
                fout[F_S]  = res[7];
                fout[F_Z]  = ~|res;
                fout[F_H]  = 1'b0;
                fout[F_PV] = ~^res;
                fout[F_N]  = 1'b0;
                fout[F_C]  = cy;
            end
            GRP_TEST: begin
                fout[F_Z] = ~val[bitn];
                fout[F_H] = 1'b1;
                fout[F_N] = 1'b0;
            end
            GRP_CLR: res[bitn] = 1'b0;
            GRP_SET: res[bitn] = 1'b1;
        endcase
    end

endmodule

// File: rtl/cbx_tcount.sv
module cbx_tcount #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [TW-1:0] ld_val,
    input  logic          add,
    input  logic [TW-1:0] add_val,
    output logic [TW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (add) cnt <= cnt + add_val;
    end

endmodule

// File: rtl/cbx_unit.sv
module cbx_unit
    import cbx_pkg::*;
#(
    parameter int AW = 16,
    parameter int TW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          opcode,
    input  logic [BYTE_W*NREG-1:0] reg_bank,
    input  logic [7:0]          flags_in,
    input  logic [AW-1:0]       hl_ptr,
    output logic                busy,
    output logic                done,
    output logic [TW-1:0]       tstates,
    output logic                wb_en,
    output logic [2:0]          wb_sel,
    output logic [7:0]          wb_data,
    output logic                flags_we,
    output logic [7:0]          flags_out,
    output logic                undoc,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata,
    input  logic                mem_ready
);

    localparam logic [TW-1:0] T_REG_LD = TW'(T_FETCH);
    localparam logic [TW-1:0] T_MEM_LD = TW'(T_FETCH + T_READ + T_INT);
    localparam logic [TW-1:0] T_WR_ADD = TW'(T_WRITE);
    localparam logic [TW-1:0] T_ONE    = TW'(1);

    cbx_state_e state_q, state_d;

    logic [7:0]    opc_q, val_q, fin_q;
    logic [AW-1:0] hl_q;
    logic [7:0]    sel_val, alu_res, alu_flags;
    logic          is_test, flag_upd, is_undoc;
    logic          take;
    logic          cnt_add;
    logic [TW-1:0] cnt_add_val;

    assign take = (state_q == ST_IDLE) && start;

    cbx_operand_sel #(.DW(BYTE_W), .NR(NREG)) i_sel (
        .bank (reg_bank),
        .sel  (opcode[2:0]),
        .val  (sel_val)
    );

    cbx_operate i_op (
        .opc      (opc_q),
        .val      (val_q),
        .fin      (fin_q),
        .res      (alu_res),
        .fout     (alu_flags),
        .is_test  (is_test),
        .flag_upd (flag_upd),
        .is_undoc (is_undoc)
    );

    assign cnt_add = ((state_q == ST_MRD)  && !mem_ready) ||
                     ((state_q == ST_MWR)  && !mem_ready) ||
                     ((state_q == ST_MINT) && !is_test);
    assign cnt_add_val = (state_q == ST_MINT) ? T_WR_ADD : T_ONE;

    cbx_tcount #(.TW(TW)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (take),
        .ld_val  ((opcode[2:0] == MEM_CODE) ? T_MEM_LD : T_REG_LD),
        .add     (cnt_add),
        .add_val (cnt_add_val),
        .cnt     (tstates)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (opcode[2:0] == MEM_CODE) ? ST_MRD : ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
            ST_MRD:  if (mem_ready) state_d = ST_MINT;
            ST_MINT: state_d = is_test ? ST_IDLE : ST_MWR;
            ST_MWR:  if (mem_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand and context capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q <= '0;
            val_q <= '0;
            fin_q <= '0;
            hl_q  <= '0;
        end else if (take) begin
            opc_q <= opcode;
            val_q <= sel_val;
            fin_q <= flags_in;
            hl_q  <= hl_ptr;
        end else if ((state_q == ST_MRD) && mem_ready) begin
            val_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        busy   = 1'b1;
        done   = 1'b0;
        wb_en  = 1'b0;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_EXEC: begin
                done  = 1'b1;
                wb_en = !is_test;
            end
            ST_MRD:  mem_rd = 1'b1;
            ST_MINT: done = is_test;
            ST_MWR: begin
                mem_wr = 1'b1;
                done   = mem_ready;
            end
            default: busy = 1'b0;
        endcase
    end

    assign flags_we  = done && flag_upd;
    assign undoc     = done && is_undoc;
    assign flags_out = alu_flags;
    assign wb_sel    = opc_q[2:0];
    assign wb_data   = alu_res;
    assign mem_wdata = alu_res;
    assign mem_addr  = hl_q;

endmodule

module cbx_unit_chk #(
    parameter int AW = 16,
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [TW-1:0] tstates,
    input logic          wb_en,
    input logic          flags_we,
    input logic          undoc,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [7:0]    mem_wdata,
    input logic          mem_ready
);

    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r8_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    a_r9_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    a_r7_wb_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    a_r10_undoc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        undoc |-> (done && flags_we));

    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_min_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tstates >= TW'(8)));

    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr || done || wb_en || flags_we || undoc));

endmodule

bind cbx_unit cbx_unit_chk #(.AW(AW), .TW(TW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .tstates   (tstates),
    .wb_en     (wb_en),
    .flags_we  (flags_we),
    .undoc     (undoc),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/test_cbx_unit.sv
module test_cbx_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] reg_bank = '0;
    logic [7:0]  flags_in = '0;
    logic [15:0] hl_ptr = '0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;

    logic        busy, done, wb_en, flags_we, undoc, mem_rd, mem_wr;
    logic [7:0]  tstates, wb_data, flags_out, mem_wdata;
    logic [2:0]  wb_sel;
    logic [15:0] mem_addr;

    int checks = 0;
    int fails  = 0;

    cbx_unit i_cbx_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .reg_bank(reg_bank), .flags_in(flags_in), .hl_ptr(hl_ptr),
        .busy(busy), .done(done), .tstates(tstates), .wb_en(wb_en),
        .wb_sel(wb_sel), .wb_data(wb_data), .flags_we(flags_we),
        .flags_out(flags_out), .undoc(undoc), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic int operand_of(input int j);
        case (j)
            0: return 'h00;
            1: return 'h01;
            2: return 'h80;
            3: return 'hFF;
            4: return 'h5A;
            5: return 'hA5;
            default: return 'h3C;
        endcase
    endfunction

    // behavioural reference, arithmetic on integers
    function automatic void expect_op(input int op, input int v, input int fin,
                                      output int res, output int fout, output bit fwe);
        int grp, sub, cin, cout, ones;
        grp = op / 64;
        sub = (op / 8) % 8;
        cin = fin % 2;
        res = v; fout = fin; fwe = 0; cout = 0;
        if (grp == 0) begin
            if (sub % 2 == 0) cout = v / 128; else cout = v % 2;
            case (sub)
                0: res = (v * 2) % 256 + v / 128;
                1: res = v / 2 + (v % 2) * 128;
                2: res = (v * 2) % 256 + cin;
                3: res = v / 2 + cin * 128;
                4: res = (v * 2) % 256;
                5: res = v / 2 + (v / 128) * 128;
                6: res = (v * 2) % 256 + 1;
                default: res = v / 2;
            endcase
            ones = 0;
            for (int b = 0; b < 8; b++) ones += (res >> b) & 1;
            fout = (res >= 128 ? 128 : 0) + (res == 0 ? 64 : 0) + (fin & 'h28)
                 + (ones % 2 == 0 ? 4 : 0) + cout;
            fwe = 1;
        end else if (grp == 1) begin
            fout = (fin & 'hAD) + (((v >> sub) & 1) == 1 ? 0 : 64) + 16;
            fwe = 1;
        end else if (grp == 2) begin
            res = v & (255 - (1 << sub));
        end else begin
            res = v | (1 << sub);
        end
    endfunction

    task automatic run(input int op, input int v, input int cin, input int rw, input int ww, input bit poke);
        int src, grp, res, fout, hl, rd_n, wr_n, addr_bad, wd_bad, wb_early, done_k;
        int exp_k, exp_t, got_t, got_wbe, got_sel, got_wbd, got_fwe, got_fo, got_und;
        bit fwe, is_mem, is_test;
        string tg, ftg;
        src = op % 8;
        grp = op / 64;
        is_mem = (src == 6);
        is_test = (grp == 1);
        tg  = (grp == 0) ? "R3" : (grp == 1) ? "R5" : "R6";
        ftg = (grp == 0) ? "R4" : tg;
        hl = ((op * 257) ^ (v * 13) ^ 'h4C1) & 'hFFFF;
        expect_op(op, v, cin ? 'hD5 : 'h2A, res, fout, fwe);
        rd_n = 0; wr_n = 0; addr_bad = 0; wd_bad = 0; wb_early = 0; done_k = 0;
        got_t = 0; got_wbe = 0; got_sel = 0; got_wbd = 0; got_fwe = 0; got_fo = 0; got_und = 0;

        @(negedge clk);
        mem_ready = 1'b0;
        start = 1'b1;
        opcode = 8'(op);
        flags_in = cin ? 8'hD5 : 8'h2A;
        hl_ptr = 16'(hl);
        for (int k = 0; k < 8; k++)
            reg_bank[k*8 +: 8] = (k == src && !is_mem) ? 8'(v) : (k == 6 ? 8'(255 - v) : 8'(k * 37 + 9));

        for (int k = 1; k < 40; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start = poke ? 1'b1 : 1'b0;
                if (poke) opcode = 8'(op ^ 'h48);
            end else if (k == 2) begin
                start = 1'b0;
                opcode = 8'(op);
            end
            if (mem_rd) begin
                rd_n++;
                if (mem_addr !== 16'(hl)) addr_bad++;
                mem_rdata = 8'(v);
                mem_ready = (rd_n > rw);
            end else if (mem_wr) begin
                wr_n++;
                if (mem_addr !== 16'(hl)) addr_bad++;
                if (mem_wdata !== 8'(res)) wd_bad++;
                mem_ready = (wr_n > ww);
            end else begin
                mem_ready = 1'b0;
            end
            #1;
            if (wb_en && !done) wb_early++;
            if (done) begin
                done_k  = k;
                got_t   = int'(tstates);
                got_wbe = int'(wb_en);
                got_sel = int'(wb_sel);
                got_wbd = int'(wb_data);
                got_fwe = int'(flags_we);
                got_fo  = int'(flags_out);
                got_und = int'(undoc);
                break;
            end
        end
        start = 1'b0;

        exp_k = !is_mem ? 1 : (is_test ? 2 + rw : 3 + rw + ww);
        exp_t = !is_mem ? 8 : (is_test ? 12 + rw : 15 + rw + ww);
        chk(is_mem ? "R8" : "R7", "done cycle", 32'(done_k), 32'(exp_k));
        chk(is_mem ? (is_test ? "R8" : "R9") : "R7", "tstates", 32'(got_t), 32'(exp_t));
        chk("R8", "read strobes", 32'(rd_n), 32'(is_mem ? rw + 1 : 0));
        chk("R9", "write strobes", 32'(wr_n), 32'(is_mem && !is_test ? ww + 1 : 0));
        chk("R8", "address mismatches", 32'(addr_bad), 32'd0);
        chk(tg, "memory write data mismatches", 32'(wd_bad), 32'd0);
        chk("R1", "write-back enable", 32'(got_wbe), 32'(!is_mem && !is_test));
        chk("R7", "write-back outside done", 32'(wb_early), 32'd0);
        if (!is_mem && !is_test) begin
            chk("R1", "write-back select", 32'(got_sel), 32'(src));
            chk(tg, "R2 result", 32'(got_wbd), 32'(res));
        end
        chk(ftg, "flag write enable", 32'(got_fwe), 32'(fwe));
        chk(ftg, "flags", 32'(got_fo), 32'(fout));
        chk("R10", "undocumented pulse", 32'(got_und), 32'(op / 8 == 6));
        if (poke) chk("R11", "start while busy ignored", 32'(done_k == exp_k && wd_bad == 0), 32'd1);
    endtask

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "busy after reset", 32'(busy), 32'd0);
        chk("R12", "done after reset", 32'(done), 32'd0);
        chk("R12", "strobes after reset", 32'(mem_rd | mem_wr), 32'd0);
        chk("R12", "write enables after reset", 32'(wb_en | flags_we | undoc), 32'd0);

        for (int op = 0; op < 256; op++)
            for (int j = 0; j < 7; j++)
                for (int c = 0; c < 2; c++)
                    run(op, operand_of(j), c, (j + op) % 3, (j + c) % 3, 1'b0);

        // start pulses during busy memory instructions
        run('h06, 'h81, 0, 2, 1, 1'b1);
        run('hCE, 'h10, 1, 2, 2, 1'b1);
        run('h46, 'h01, 0, 1, 0, 1'b1);
        run('h36, 'h80, 1, 2, 0, 1'b1);

        @(negedge clk);
        chk("R12", "idle after last run", 32'(busy | mem_rd | mem_wr), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule